// File: doc/BRIEF.md
# Reconfigurable Weighted Threshold Cell

This block is a cycle-level digital model of a single threshold cell whose Boolean function is chosen at run time. Three data inputs each carry a small integer weight; a control input carries a weight of its own. The cell fires when the weighted count of high inputs, with the control weight added whenever the control input is high, reaches a margin. A high control input therefore lowers the effective margin and turns one function into another, for example a three-input AND into a three-input OR.

The cell works in two alternating phases chosen by `discharge`. While `discharge` is high, the internal sum node is held at zero. While it is low, the cell evaluates: the sum node registers the weighted sum of the present inputs every cycle. On the first clock edge of the next discharge phase, the result of the last evaluate cycle is moved into the output registers. The outputs then hold until the next such edge. A 4-bit preset code chooses the weights and the margin from a fixed set of function pairs, and unused codes are flagged.

Top module: `morph_thresh_gate`

## Requirements
- R1: After synchronous reset, `out_f` is 0, `out_fn` is 1 and `cfg_err` is 0, and the sum node is 0.
- R2: With a valid preset, `out_fn` is 0 (and `out_f` is 1) exactly when the sum of the weights of the high data inputs, plus the control weight if `ctl` is 1, is at least the margin k. The inputs sampled are those of the last evaluate cycle (`discharge`=0), and the result appears on the first rising edge at which `discharge` is 1.
- R3: Preset 0 uses weights a=1, b=1, c=0, k=2 and control weight 1. It gives a&b when `ctl`=0 and a|b when `ctl`=1, and `in_c` has no effect.
- R4: Preset 1 uses weights 1,1,1, k=3 and control weight 2. It gives a&b&c when `ctl`=0 and a|b|c when `ctl`=1.
- R5: Preset 2 uses weights 1,1,1, k=3 and control weight 1. It gives a&b&c when `ctl`=0 and the majority of a,b,c when `ctl`=1.
- R6: Preset 3 uses weights a=1, b=1, c=2, k=3 and control weight 1. It gives (a|b)&c when `ctl`=0 and (a&b)|c when `ctl`=1.
- R7: Presets 4 and 5 use weights a=1, b=1, c=2 and k=4, with control weight 2 for preset 4 and 1 for preset 5. Both give a&b&c when `ctl`=0; when `ctl`=1, preset 4 gives (a&b)|c and preset 5 gives (a|b)&c.
- R8: Preset 6 uses weights 1,1,1, k=2 and control weight 1, giving the majority when `ctl`=0 and a|b|c when `ctl`=1. Preset 7 uses weights a=1, b=1, c=2, k=3 and control weight 2, giving (a|b)&c when `ctl`=0 and a|b|c when `ctl`=1.
- R9: A preset code of 8 to 15 captured in the last evaluate cycle gives `out_f`=0, `out_fn`=0 and `cfg_err`=1. Codes 0 to 7 give `cfg_err`=0.
- R10: Outputs change only on the first rising edge of a discharge phase. During the remaining discharge cycles and during evaluate cycles they hold, whatever `in_a`, `in_b`, `in_c`, `ctl` and `preset_sel` do.
- R11: In an evaluate phase of several cycles, only the inputs of the final evaluate cycle decide the result. The sum node reads 0 in the cycle after any edge sampled with `discharge` high.
- R12: Whenever `cfg_err` is 0, `out_fn` is the complement of `out_f`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| discharge | input | 1 | Phase select: 1 clears the sum node, 0 evaluates |
| in_a | input | 1 | Data input A |
| in_b | input | 1 | Data input B |
| in_c | input | 1 | Data input C |
| ctl | input | 1 | Control input; adds its weight to the sum when high |
| preset_sel | input | 4 | Preset code selecting weights and margin |
| out_f | output | 1 | Registered true output |
| out_fn | output | 1 | Registered inverted output |
| cfg_err | output | 1 | Registered flag for an unused preset code |

## Verification
The hardest situation to bring about from the ports is an evaluate phase longer than one cycle, in which earlier evaluate cycles present inputs that would give a different answer from the final one. A related case is a discharge phase in which the inputs, the control and the preset code all move while the outputs must stay put. The stimulus therefore wraps every checked vector in a random number of leading evaluate cycles with random inputs and a random number of trailing discharge cycles with random inputs and codes. The result must follow only the final evaluate cycle and must hold through every trailing discharge cycle. A directed sweep over all eight input patterns with each control level, for every preset code, covers the function pairs and the error codes.

// File: rtl/mtg_pkg.sv
package mtg_pkg;
  localparam int N_DATA = 3;
  localparam int WGT_W  = 3;
  localparam int SEL_W  = 4;
  localparam int SUM_W  = $clog2((N_DATA + 1) * ((1 << WGT_W) - 1) + 1);

  typedef struct packed {
    logic                          valid;
    logic [N_DATA-1:0][WGT_W-1:0] w;
    logic [WGT_W-1:0]              w_ct;
    logic [SUM_W-1:0]              k;
  } preset_t;

  function automatic preset_t mk(input int wa, input int wb, input int wc,
                                 input int wct, input int k);
    preset_t p;
    p.valid = 1'b1;
    p.w[0]  = WGT_W'(wa);
    p.w[1]  = WGT_W'(wb);
    p.w[2]  = WGT_W'(wc);
    p.w_ct  = WGT_W'(wct);
    p.k     = SUM_W'(k);
    return p;
  endfunction

  function automatic preset_t preset_lookup(input logic [SEL_W-1:0] sel);
    preset_t p;
    p = '0;
    case (sel)
      SEL_W'(0): p = mk(1, 1, 0, 1, 2);
      SEL_W'(1): p = mk(1, 1, 1, 2, 3);
      SEL_W'(2): p = mk(1, 1, 1, 1, 3);
      SEL_W'(3): p = mk(1, 1, 2, 1, 3);
      SEL_W'(4): p = mk(1, 1, 2, 2, 4);
      SEL_W'(5): p = mk(1, 1, 2, 1, 4);
      SEL_W'(6): p = mk(1, 1, 1, 1, 2);
      SEL_W'(7): p = mk(1, 1, 2, 2, 3);
      default:   p = '0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/mtg_preset_dec.sv
module mtg_preset_dec
  import mtg_pkg::*;
#(
  parameter int SEL_BITS = SEL_W
) (
  input  logic [SEL_BITS-1:0] sel,
  output preset_t             cfg
);
  always_comb begin
    cfg = preset_lookup(SEL_W'(sel));
  end
endmodule

// File: rtl/mtg_sum_node.sv
module mtg_sum_node
  import mtg_pkg::*;
#(
  parameter int N_IN = N_DATA,
  parameter int SW   = SUM_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            discharge,
  input  logic [N_IN-1:0] data,
  input  logic            ctl,
  input  preset_t         cfg,
  output logic [SW-1:0]   sum_q,
  output logic [SW-1:0]   k_q,
  output logic            err_q
);
  logic [N_IN-1:0][SW-1:0] term;
  logic [SW-1:0]           ctl_term;
  logic [SW-1:0]           sum_d;

  for (genvar i = 0; i < N_IN; i++) begin : g_term
    assign term[i] = data[i] ? SW'(cfg.w[i]) : '0;
  end

  assign ctl_term = ctl ? SW'(cfg.w_ct) : '0;

  always_comb begin
    sum_d = ctl_term;
    for (int i = 0; i < N_IN; i++) begin
      sum_d = sum_d + term[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || discharge) begin
      sum_q <= '0;
      k_q   <= '0;
      err_q <= 1'b0;
    end else begin
      sum_q <= sum_d;
      k_q   <= SW'(cfg.k);
      err_q <= ~cfg.valid;
    end
  end
endmodule

// File: rtl/mtg_out_stage.sv
module mtg_out_stage #(
  parameter int SW = mtg_pkg::SUM_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          discharge,
  input  logic [SW-1:0] sum_q,
  input  logic [SW-1:0] k_q,
  input  logic          err_q,
  output logic          out_f,
  output logic          out_fn,
  output logic          cfg_err
);
  logic was_eval;
  logic fire;

  assign fire = (sum_q >= k_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      was_eval <= 1'b0;
      out_f    <= 1'b0;
      out_fn   <= 1'b1;
      cfg_err  <= 1'b0;
    end else begin
      was_eval <= ~discharge;
      if (discharge && was_eval) begin
        if (err_q) begin
          out_f   <= 1'b0;
          out_fn  <= 1'b0;
          cfg_err <= 1'b1;
        end else begin
          out_f   <= fire;
          out_fn  <= ~fire;
          cfg_err <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/morph_thresh_gate.sv
module morph_thresh_gate
  import mtg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             discharge,
  input  logic             in_a,
  input  logic             in_b,
  input  logic             in_c,
  input  logic             ctl,
  input  logic [SEL_W-1:0] preset_sel,
  output logic             out_f,
  output logic             out_fn,
  output logic             cfg_err
);
  preset_t          cfg;
  logic [SUM_W-1:0] sum_q;
  logic [SUM_W-1:0] k_q;
  logic             err_q;

  mtg_preset_dec #(.SEL_BITS(SEL_W)) u_dec (
    .sel (preset_sel),
    .cfg (cfg)
  );

  mtg_sum_node #(.N_IN(N_DATA), .SW(SUM_W)) u_sum (
    .clk       (clk),
    .rst       (rst),
    .discharge (discharge),
    .data      ({in_c, in_b, in_a}),
    .ctl       (ctl),
    .cfg       (cfg),
    .sum_q     (sum_q),
    .k_q       (k_q),
    .err_q     (err_q)
  );

  mtg_out_stage #(.SW(SUM_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .discharge (discharge),
    .sum_q     (sum_q),
    .k_q       (k_q),
    .err_q     (err_q),
    .out_f     (out_f),
    .out_fn    (out_fn),
    .cfg_err   (cfg_err)
  );
endmodule

// File: rtl/morph_thresh_gate_chk.sv
module morph_thresh_gate_chk #(
  parameter int SW = mtg_pkg::SUM_W
) (
  input logic          clk,
  input logic          rst,
  input logic          discharge,
  input logic          out_f,
  input logic          out_fn,
  input logic          cfg_err,
  input logic [SW-1:0] sum_q
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst || rst_d)
    cfg_err |-> (!out_f && !out_fn));

  p_rails_split_r12: assert property (@(posedge clk) disable iff (rst || rst_d)
    !cfg_err |-> (out_f != out_fn));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst || rst_d)
    (!discharge || $past(discharge)) |=>
      ($stable(out_f) && $stable(out_fn) && $stable(cfg_err)));

  p_sum_clear_r11: assert property (@(posedge clk) disable iff (rst || rst_d)
    discharge |=> (sum_q == '0));
endmodule

bind morph_thresh_gate morph_thresh_gate_chk #(.SW(mtg_pkg::SUM_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .discharge (discharge),
  .out_f     (out_f),
  .out_fn    (out_fn),
  .cfg_err   (cfg_err),
  .sum_q     (sum_q)
);

// File: tb/morph_thresh_gate_tb_top.sv
`timescale 1ns/1ps
module morph_thresh_gate_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       discharge = 1'b1;
  logic       in_a = 1'b0, in_b = 1'b0, in_c = 1'b0, ctl = 1'b0;
  logic [3:0] preset_sel = 4'd0;
  logic       out_f, out_fn, cfg_err;
  int         total = 0;
  int         bad = 0;

  always #5 clk = ~clk;

  morph_thresh_gate dut_i (
    .clk(clk), .rst(rst), .discharge(discharge),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .ctl(ctl),
    .preset_sel(preset_sel),
    .out_f(out_f), .out_fn(out_fn), .cfg_err(cfg_err)
  );

  function automatic string req_of(input logic [3:0] sel);
    case (sel)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4, 4'd5: return "R7";
      4'd6, 4'd7: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic ref_f(input logic [3:0] sel, input logic a,
                                 input logic b, input logic c, input logic k);
    logic and3, or3, maj, oa, ao;
    and3 = a & b & c;
    or3  = a | b | c;
    maj  = (a & b) | (b & c) | (a & c);
    oa   = (a | b) & c;
    ao   = (a & b) | c;
    case (sel)
      4'd0: return k ? (a | b) : (a & b);
      4'd1: return k ? or3 : and3;
      4'd2: return k ? maj : and3;
      4'd3: return k ? ao : oa;
      4'd4: return k ? ao : and3;
      4'd5: return k ? oa : and3;
      4'd6: return k ? or3 : maj;
      4'd7: return k ? or3 : oa;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [2:0] ref_out(input logic [3:0] sel, input logic a,
                                         input logic b, input logic c, input logic k);
    logic f;
    if (sel >= 4'd8) return 3'b001;
    f = ref_f(sel, a, b, c, k);
    return {f, ~f, 1'b0};
  endfunction

  task automatic check(input string req, input logic [2:0] exp);
    total++;
    if ({out_f, out_fn, cfg_err} !== exp) begin
      bad++;
      $display("FAIL %s: got f/fn/err=%b expected %b", req, {out_f, out_fn, cfg_err}, exp);
    end
  endtask

  task automatic junk_inputs(input bit move_sel);
    in_a = 1'($urandom);
    in_b = 1'($urandom);
    in_c = 1'($urandom);
    ctl  = 1'($urandom);
    if (move_sel) preset_sel = 4'($urandom);
  endtask

  // One full evaluate/discharge round; checks result then hold.
  task automatic round(input logic [3:0] sel, input logic [2:0] abc, input logic k,
                       input int n_pre, input int n_hold);
    logic [2:0] exp;
    exp = ref_out(sel, abc[0], abc[1], abc[2], k);
    for (int i = 0; i < n_pre; i++) begin
      @(negedge clk);
      discharge = 1'b0;
      junk_inputs(1'b1);
    end
    @(negedge clk);
    discharge = 1'b0;
    preset_sel = sel;
    {in_c, in_b, in_a} = abc;
    ctl = k;
    @(negedge clk);
    discharge = 1'b1;
    junk_inputs(1'b1);
    @(negedge clk);
    check((n_pre > 0) ? {req_of(sel), " R11 R2"} : {req_of(sel), " R2"}, exp);
    for (int j = 0; j < n_hold; j++) begin
      junk_inputs(1'b1);
      @(negedge clk);
      check("R10", exp);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 3'b010);

    // Directed sweep: every preset code, both control levels, all inputs.
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 2; k++) begin
        for (int v = 0; v < 8; v++) begin
          round(4'(s), 3'(v), 1'(k), 0, 0);
        end
      end
    end

    // R3: in_c has no effect in preset 0.
    round(4'd0, 3'b100, 1'b1, 0, 1);
    round(4'd0, 3'b111, 1'b0, 0, 1);

    // R11: long evaluate phase, result from last cycle only.
    round(4'd1, 3'b000, 1'b1, 3, 2);
    round(4'd4, 3'b111, 1'b0, 4, 1);

    // Random rounds with variable evaluate and discharge lengths.
    for (int r = 0; r < 300; r++) begin
      round(4'($urandom_range(0, 15)), 3'($urandom), 1'($urandom),
            int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
    end

    // R1: reset again mid-run.
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", 3'b010);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule